// File: doc/BRIEF.md
# USB Line State Decoder with Idle Reset Timer

This block sits between the line receivers of a USB 2.0 transceiver and the serial interface engine. It turns the single-ended receiver bits, the high-speed differential receiver bit and the squelch detector into the two-bit line condition code the engine reads. The decoding depends on the operating mode, which the engine picks with two controls, `xcvr_sel` and `term_sel`:

- In full-speed operation the code follows the single-ended receivers.
- In high-speed operation any unsquelched bus reads as J. This keeps the code from toggling with every data bit.
- In chirp operation J and K come from the differential receiver, and only while the bus is unsquelched.

The block also watches for a bus reset while the high-speed transceiver is selected. It counts consecutive clock cycles in which the registered code is SE0. After `IDLE_CYCLES = CLK_HZ * IDLE_US / 1_000_000` such cycles (3 ms by default) it raises `bus_reset_det`. The flag holds until the bus leaves SE0 or full speed is selected.

The timer is a three-state machine:

- **TMR_ARMED**: not counting. It moves to TMR_COUNTING on the first idle cycle.
- **TMR_COUNTING**: accumulates idle cycles. It returns to TMR_ARMED on any non-idle cycle. It moves to TMR_RESET_SEEN when the last idle cycle is counted.
- **TMR_RESET_SEEN**: the flag is high. It returns to TMR_ARMED on the first non-idle cycle.

Top module: `usb_linestate_top`

## Requirements
- R1: The line code on `line_state` uses 00 = SE0, 01 = J, 10 = K, 11 = SE1.
- R2: With `xcvr_sel`=1 and `term_sel`=1 (full speed), the code is taken from the single-ended receivers: `dp_rx`=0 and `dm_rx`=0 gives SE0, both 1 gives SE1, `dp_rx`=1 with `dm_rx`=0 gives J, and `dp_rx`=0 with `dm_rx`=1 gives K. `hs_diff_rx` and `squelch` have no effect.
- R3: With `xcvr_sel`=1 and `term_sel`=0, the code follows the same single-ended rules as R2.
- R4: With `xcvr_sel`=0 and `term_sel`=0 (high speed), `squelch`=1 gives SE0 regardless of `hs_diff_rx`, `dp_rx` and `dm_rx`.
- R5: In high speed with `squelch`=0, the code is J whatever `hs_diff_rx`, `dp_rx` and `dm_rx` are.
- R6: With `xcvr_sel`=0 and `term_sel`=1 (chirp), `squelch`=1 gives SE0. With `squelch`=0, `hs_diff_rx`=1 gives J and `hs_diff_rx`=0 gives K.
- R7: The receiver inputs pass through a two-flop synchronizer and a registered output. A change applied before rising edge n shows on `line_state` after edge n+2 and not after edge n+1.
- R8: When `xcvr_sel`=0 and `line_state` is SE0 at every edge, `bus_reset_det` rises on the edge that completes IDLE_CYCLES such edges, and not one edge earlier. This holds in high-speed and in chirp mode.
- R9: Once set, `bus_reset_det` stays high while idle continues. It clears on the first edge at which `line_state` is not SE0 or `xcvr_sel`=1.
- R10: A single non-idle cycle restarts the count, so a later idle stretch again needs the full IDLE_CYCLES.
- R11: While `rst_n` is low, `line_state` is SE0 and `bus_reset_det` is 0.
- R12: IDLE_CYCLES equals CLK_HZ * IDLE_US / 1_000_000, computed in 64-bit arithmetic (180000 at the defaults).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_rx | input | 1 | Single-ended receiver output for DP |
| dm_rx | input | 1 | Single-ended receiver output for DM |
| hs_diff_rx | input | 1 | High-speed differential receiver output |
| squelch | input | 1 | 1 when the bus is below the squelch threshold |
| xcvr_sel | input | 1 | 1 selects the full-speed transceiver, 0 the high-speed one |
| term_sel | input | 1 | 1 selects full-speed termination |
| line_state | output | 2 | Registered line condition code |
| bus_reset_det | output | 1 | High after the idle reset interval |

## Verification
A receiver-input change is due on `line_state` exactly three rising edges after it is driven, and the bench samples one nanosecond after that third edge. The latency case also samples after the second edge, where it expects the old code. The mode controls bypass the synchronizer. Each vector therefore changes all inputs at one falling edge, so that the third edge sees a settled value. `bus_reset_det` is expected to rise on edge IDLE_CYCLES+3 after idle is driven, because three edges fill the pipeline before counting starts. The bench checks the flag after edge IDLE_CYCLES+2 and again after edge IDLE_CYCLES+3. It expects a clear one edge after the line code leaves SE0, or one edge after full speed is selected.

// File: rtl/usb_ls_pkg.sv
`timescale 1ns/1ps
package usb_ls_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_code_e;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_HIGH  = 2'd1,
        MODE_CHIRP = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        TMR_ARMED      = 2'd0,
        TMR_COUNTING   = 2'd1,
        TMR_RESET_SEEN = 2'd2
    } idle_state_e;

    // Full-speed transceiver wins regardless of termination.
    function automatic bus_mode_e mode_of(input logic xcvr, input logic term);
        if (xcvr)      return MODE_FULL;
        else if (term) return MODE_CHIRP;
        else           return MODE_HIGH;
    endfunction

endpackage

// File: rtl/ls_sync.sv
`timescale 1ns/1ps
module ls_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/ls_decode.sv
`timescale 1ns/1ps
module ls_decode
    import usb_ls_pkg::*;
(
    input  bus_mode_e  mode,
    input  logic       dp,
    input  logic       dm,
    input  logic       hs_diff,
    input  logic       sq,
    output line_code_e code
);
    line_code_e se_code;

    // Single-ended view used by full-speed operation.
    always_comb begin
        unique case ({dp, dm})
            2'b00:   se_code = LS_SE0;
            2'b10:   se_code = LS_J;
            2'b01:   se_code = LS_K;
            default: se_code = LS_SE1;
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_FULL:  code = se_code;
            MODE_HIGH:  code = sq ? LS_SE0 : LS_J;
            MODE_CHIRP: code = sq ? LS_SE0 : (hs_diff ? LS_J : LS_K);
            default:    code = se_code;
        endcase
    end
endmodule

// File: rtl/ls_idle_timer.sv
`timescale 1ns/1ps
module ls_idle_timer
    import usb_ls_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 180000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_sel,
    input  line_code_e line_code,
    output logic       reset_det
);
    localparam int CNT_W = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(IDLE_CYCLES - 1);

    idle_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic idle_now;

    assign idle_now = hs_sel && (line_code == LS_SE0);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_ARMED: begin
                if (idle_now) begin
                    state_d = TMR_COUNTING;
                    cnt_d   = CNT_W'(1);
                end
            end
            TMR_COUNTING: begin
                if (!idle_now) begin
                    state_d = TMR_ARMED;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = TMR_RESET_SEEN;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            TMR_RESET_SEEN: begin
                if (!idle_now) begin
                    state_d = TMR_ARMED;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = TMR_ARMED;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            TMR_RESET_SEEN: reset_det = 1'b1;
            default:        reset_det = 1'b0;
        endcase
    end
endmodule

// File: rtl/usb_linestate_top.sv
`timescale 1ns/1ps
module usb_linestate_top
    import usb_ls_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 60_000_000,
    parameter int unsigned IDLE_US = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_rx,
    input  logic       dm_rx,
    input  logic       hs_diff_rx,
    input  logic       squelch,
    input  logic       xcvr_sel,
    input  logic       term_sel,
    output logic [1:0] line_state,
    output logic       bus_reset_det
);
    localparam longint unsigned CYC64 =
        (64'(CLK_HZ) * 64'(IDLE_US)) / 64'd1_000_000;
    localparam int unsigned IDLE_CYCLES = 32'(CYC64);

    logic [3:0] raw_in, sync_out;
    logic dp_s, dm_s, diff_s, sq_s;
    bus_mode_e mode;
    line_code_e code_d, line_q;

    assign raw_in = {dp_rx, dm_rx, hs_diff_rx, squelch};

    ls_sync #(.WIDTH(4), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    assign {dp_s, dm_s, diff_s, sq_s} = sync_out;
    assign mode = mode_of(xcvr_sel, term_sel);

    ls_decode u_dec (
        .mode    (mode),
        .dp      (dp_s),
        .dm      (dm_s),
        .hs_diff (diff_s),
        .sq      (sq_s),
        .code    (code_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= LS_SE0;
        else        line_q <= code_d;
    end

    assign line_state = line_q;

    ls_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_sel    (!xcvr_sel),
        .line_code (line_q),
        .reset_det (bus_reset_det)
    );
endmodule

// File: rtl/ls_checker.sv
`timescale 1ns/1ps
module ls_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       xcvr_sel,
    input logic       term_sel,
    input logic       dp_s,
    input logic       dm_s,
    input logic       diff_s,
    input logic       sq_s,
    input logic [1:0] line_state,
    input logic       bus_reset_det
);
    a_r2_full_speed_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xcvr_sel) |-> (line_state == {$past(dm_s), $past(dp_s)}));

    a_r4_high_squelch_se0: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(xcvr_sel) && $past(sq_s)) |-> (line_state == 2'b00));

    a_r5_high_active_j: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(xcvr_sel) && !$past(term_sel) && !$past(sq_s)) |-> (line_state == 2'b01));

    a_r6_chirp_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(xcvr_sel) && $past(term_sel) && !$past(sq_s))
            |-> (line_state == ($past(diff_s) ? 2'b01 : 2'b10)));

    a_r8_rise_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_reset_det) |-> (!$past(xcvr_sel) && $past(line_state) == 2'b00));

    a_r9_clear_on_activity: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_det && (xcvr_sel || line_state != 2'b00)) |=> !bus_reset_det);

    a_r9_hold_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset_det && !xcvr_sel && line_state == 2'b00) |=> bus_reset_det);
endmodule

bind usb_linestate_top ls_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xcvr_sel      (xcvr_sel),
    .term_sel      (term_sel),
    .dp_s          (dp_s),
    .dm_s          (dm_s),
    .diff_s        (diff_s),
    .sq_s          (sq_s),
    .line_state    (line_state),
    .bus_reset_det (bus_reset_det)
);

// File: tb/tb_usb_linestate_top.sv
`timescale 1ns/1ps
module tb_usb_linestate_top;
    localparam int unsigned CLK_HZ  = 20000;
    localparam int unsigned IDLE_US = 3000;
    localparam int N = 60;   // R12: 20000 * 3000 / 1e6

    typedef struct {
        logic [1:0] ls;
        logic       rd;
        bit         chk_rd;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp_rx = 1'b1, dm_rx = 1'b0, hs_diff_rx = 1'b0, squelch = 1'b0;
    logic xcvr_sel = 1'b1, term_sel = 1'b1;
    logic [1:0] line_state;
    logic bus_reset_det;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    usb_linestate_top #(.CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dp_rx         (dp_rx),
        .dm_rx         (dm_rx),
        .hs_diff_rx    (hs_diff_rx),
        .squelch       (squelch),
        .xcvr_sel      (xcvr_sel),
        .term_sel      (term_sel),
        .line_state    (line_state),
        .bus_reset_det (bus_reset_det)
    );

    // Model built from the requirements.
    function automatic logic [1:0] model_ls(input logic x, input logic t, input logic dp,
                                            input logic dm, input logic df, input logic sq);
        if (x) begin
            if (!dp && !dm) return 2'b00;
            if (dp && dm)   return 2'b11;
            return dp ? 2'b01 : 2'b10;
        end
        if (sq) return 2'b00;
        if (!t) return 2'b01;
        return df ? 2'b01 : 2'b10;
    endfunction

    function automatic string req_of(input logic x, input logic t, input logic sq);
        if (x) return t ? "R2" : "R3";
        if (!t) return sq ? "R4" : "R5";
        return "R6";
    endfunction

    task automatic drive(input logic x, input logic t, input logic dp, input logic dm,
                         input logic df, input logic sq);
        @(negedge clk);
        xcvr_sel = x; term_sel = t; dp_rx = dp; dm_rx = dm; hs_diff_rx = df; squelch = sq;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_out(input logic [1:0] ls, input logic rd, input bit chk_rd,
                              input string req);
        exp_t e;
        e.ls = ls; e.rd = rd; e.chk_rd = chk_rd; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: compares one nanosecond after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (line_state !== e.ls) begin
                    n_fail++;
                    $display("FAIL %s line_state actual=%b expected=%b", e.req, line_state, e.ls);
                end else if (e.chk_rd && bus_reset_det !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s bus_reset_det actual=%b expected=%b", e.req,
                             bus_reset_det, e.rd);
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        step(3);
        expect_out(2'b00, 1'b0, 1'b1, "R11");
        step(1);
        @(negedge clk); rst_n = 1'b1;

        // R1/R2: full-speed J and K codes
        drive(1, 1, 1, 0, 0, 0); step(3);
        expect_out(2'b01, 1'b0, 1'b1, "R1 R2 J");
        // R7: exact latency, old code after edge 2, new after edge 3
        drive(1, 1, 0, 1, 0, 0); step(2);
        expect_out(2'b01, 1'b0, 0, "R7 early");
        step(1);
        expect_out(2'b10, 1'b0, 0, "R7 due");

        // R2..R6: every mode and input combination
        for (int v = 0; v < 64; v++) begin
            logic x, t, dp, dm, df, sq;
            {x, t, dp, dm, df, sq} = 6'(v);
            drive(x, t, dp, dm, df, sq); step(3);
            expect_out(model_ls(x, t, dp, dm, df, sq), 1'b0, 0, req_of(x, t, sq));
        end

        // R8 R12: flag exactly at the count in high speed
        drive(1, 1, 1, 0, 0, 0); step(4);
        drive(0, 0, 1, 0, 0, 1); step(N + 2);
        expect_out(2'b00, 1'b0, 1'b1, "R8 R12 not early");
        step(1);
        expect_out(2'b00, 1'b1, 1'b1, "R8 R12 on count");
        // R9: holds during idle, clears one edge after activity shows
        step(5);
        expect_out(2'b00, 1'b1, 1'b1, "R9 hold");
        drive(0, 0, 1, 0, 0, 0); step(3);
        expect_out(2'b01, 1'b1, 1'b1, "R9 pending");
        step(1);
        expect_out(2'b01, 1'b0, 1'b1, "R9 cleared by activity");

        // R9: full-speed select clears even with SE0 on the lines
        drive(0, 0, 0, 0, 0, 1); step(N + 3);
        expect_out(2'b00, 1'b1, 1'b1, "R8 again");
        drive(1, 1, 0, 0, 0, 1); step(1);
        expect_out(2'b00, 1'b0, 1'b1, "R9 cleared by full speed");

        // R10: interrupted idle restarts the count
        drive(1, 1, 1, 0, 0, 0); step(4);
        drive(0, 0, 1, 0, 0, 1); step(N - 5);
        drive(0, 0, 1, 0, 0, 0); step(3);
        expect_out(2'b01, 1'b0, 1'b1, "R10 interrupt");
        step(3);
        drive(0, 0, 1, 0, 0, 1); step(N + 2);
        expect_out(2'b00, 1'b0, 1'b1, "R10 full count needed");
        step(1);
        expect_out(2'b00, 1'b1, 1'b1, "R10 fires");

        // R8: chirp-mode idle also counts
        drive(1, 1, 1, 0, 0, 0); step(4);
        drive(0, 1, 1, 0, 1, 1); step(N + 2);
        expect_out(2'b00, 1'b0, 1'b1, "R8 chirp early");
        step(1);
        expect_out(2'b00, 1'b1, 1'b1, "R8 chirp on count");

        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule